// File: doc/BRIEF.md
# Byte-Serial Reflected CRC-32 Engine

This block computes a 32-bit cyclic redundancy checksum over a byte stream, one byte per clock, using the reflected (LSB-first) convention. Each message picks one of two generator polynomials at the moment it is opened: the Ethernet/zip polynomial or the Castagnoli polynomial. The running remainder is complemented when a message opens and again when the checksum is emitted. Because of this, a checksum emitted earlier can be loaded back as a seed to continue a longer message split into pieces.

A message opens with a one-cycle `start` strobe. `start` may arrive in the same cycle as the first byte, and it may carry a seed. Bytes are taken on `in_valid && in_ready`. The message closes when `in_last` is seen while `in_ready` is high. If `in_valid` is also high in that cycle, that byte is the final one. If `in_valid` is low, the message closes with no further byte, which is how an empty message is sent. One cycle later the checksum appears on `crc_out` with a single-cycle `crc_valid` pulse. `crc_out` then holds its value until the next pulse.

Top module: `crc32_byte_engine`

## Requirements
- R1: With `poly_sel`=0 (reflected polynomial 0xEDB88320), the unseeded message 0x48, 0x69, 0x0A yields `crc_out` = 0xD5223C9A, and the ASCII string "123456789" yields 0xCBF43926.
- R2: With `poly_sel`=1 at `start` (reflected polynomial 0x82F63B78), the unseeded ASCII string "123456789" yields 0xE3069283.
- R3: Each byte is consumed least-significant bit first. Each accepted byte advances the state by one reflected division step, so the output matches a bit-serial reference on arbitrary data.
- R4: An unseeded message begins from an all-ones state, and the output is the complement of the final state. A message with no bytes therefore yields 0x00000000, and a seeded message with no bytes yields the seed.
- R5: With `seed_en`=1 at `start`, the value on `seed` (a previously emitted checksum of s) followed by the bytes of t yields the checksum of s followed by t.
- R6: `crc_valid` is high for exactly one cycle, in the cycle after `in_last` was seen with `in_ready` high. `in_ready` is low during that cycle.
- R7: A cycle with `in_valid` low and `in_last` low leaves the checksum unchanged.
- R8: `poly_sel` is sampled only in the `start` cycle. Changes to it later in the message have no effect.
- R9: A byte presented in the same cycle as `start` is the first byte of the new message. `start` and `in_last` in the same cycle as a byte form a one-byte message.
- R10: After reset, `in_ready`=1, `crc_valid`=0 and `crc_out`=0. `crc_out` changes only in a cycle in which `crc_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a new message this cycle |
| seed_en | input | 1 | With `start`: begin from `seed` instead of zero |
| seed | input | 32 | Previously emitted checksum to resume from |
| poly_sel | input | 1 | With `start`: 0 selects 0xEDB88320, 1 selects 0x82F63B78 |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Engine can take a byte or a close this cycle |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Closes the message (with or without a byte) |
| crc_valid | output | 1 | One-cycle strobe: `crc_out` is fresh |
| crc_out | output | 32 | Final checksum, held between strobes |

## Verification
The hardest situations to reach are the ones where several control events coincide. These include a seed loaded in the same cycle as a byte, a close with no byte, and a polynomial switch in the middle of a message that must be ignored. The stimulus reaches them in several ways. It drives `start` together with the first byte, and it sends empty messages both seeded and unseeded. It also inserts idle gaps in which `poly_sel` is flipped. Split-message resumption is tested by feeding an emitted checksum back as the seed and comparing against the checksum of the whole string. A bit-serial model shadows every cycle of random traffic.

// File: rtl/crc32_pkg.sv
`timescale 1ns/1ps
package crc32_pkg;
  localparam int CRC_W     = 32;
  localparam int BYTE_W    = 8;
  localparam int LUT_DEPTH = 1 << BYTE_W;

  localparam logic [CRC_W-1:0] POLY_IEEE_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] POLY_CAST_REFL = 32'h82F63B78;

  typedef enum logic {
    POLY_IEEE = 1'b0,
    POLY_CAST = 1'b1
  } poly_e;

  // One reflected division step over a full byte, LSB first.
  function automatic logic [CRC_W-1:0] shift_byte(input logic [CRC_W-1:0] st,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] c;
    c = st ^ {{(CRC_W-BYTE_W){1'b0}}, b};
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [CRC_W-1:0] poly_of(input poly_e s);
    return (s == POLY_CAST) ? POLY_CAST_REFL : POLY_IEEE_REFL;
  endfunction
endpackage

// File: rtl/crc32_lut.sv
`timescale 1ns/1ps
module crc32_lut
  import crc32_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = POLY_IEEE_REFL
) (
  input  logic [BYTE_W-1:0] idx,
  output logic [CRC_W-1:0]  word
);
  logic [CRC_W-1:0] rom [LUT_DEPTH];

  for (genvar k = 0; k < LUT_DEPTH; k++) begin : g_ent
    assign rom[k] = shift_byte('0, BYTE_W'(k), POLY);
  end

  assign word = rom[idx];
endmodule

// File: rtl/crc32_step.sv
`timescale 1ns/1ps
module crc32_step
  import crc32_pkg::*;
#(
  parameter bit USE_TABLE = 1'b1
) (
  input  logic [CRC_W-1:0]  state,
  input  logic [BYTE_W-1:0] data,
  input  logic              sel,
  output logic [CRC_W-1:0]  nxt
);
  if (USE_TABLE) begin : g_tab
    logic [BYTE_W-1:0] idx;
    logic [CRC_W-1:0]  w_ieee;
    logic [CRC_W-1:0]  w_cast;

    assign idx = data ^ state[BYTE_W-1:0];

    crc32_lut #(.POLY(POLY_IEEE_REFL)) u_lut_ieee (.idx(idx), .word(w_ieee));
    crc32_lut #(.POLY(POLY_CAST_REFL)) u_lut_cast (.idx(idx), .word(w_cast));

    assign nxt = (sel ? w_cast : w_ieee) ^ (state >> BYTE_W);
  end else begin : g_net
    assign nxt = shift_byte(state, data, poly_of(poly_e'(sel)));
  end
endmodule

// File: rtl/crc32_byte_engine.sv
`timescale 1ns/1ps
module crc32_byte_engine
  import crc32_pkg::*;
#(
  parameter bit USE_TABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              seed_en,
  input  logic [CRC_W-1:0]  seed,
  input  logic              poly_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              crc_valid,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] state_q;
  logic             sel_q;
  logic [CRC_W-1:0] base;
  logic             sel_eff;
  logic [CRC_W-1:0] stepped;
  logic [CRC_W-1:0] state_d;
  logic             take;
  logic             close;

  // Entry inversion applies to the seed (or zero) when a message opens.
  always_comb begin
    base    = start ? ~(seed_en ? seed : '0) : state_q;
    sel_eff = start ? poly_sel : sel_q;
  end

  crc32_step #(.USE_TABLE(USE_TABLE)) u_step (
    .state (base),
    .data  (in_data),
    .sel   (sel_eff),
    .nxt   (stepped)
  );

  assign take    = in_valid & in_ready;
  assign close   = in_last & in_ready;
  assign state_d = take ? stepped : base;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= '1;
      sel_q     <= 1'b0;
      in_ready  <= 1'b1;
      crc_valid <= 1'b0;
      crc_out   <= '0;
    end else begin
      state_q   <= state_d;
      in_ready  <= 1'b1;
      crc_valid <= 1'b0;
      if (start) sel_q <= poly_sel;
      if (close) begin
        in_ready  <= 1'b0;
        crc_valid <= 1'b1;
        crc_out   <= ~state_d;
      end
    end
  end
endmodule

// File: rtl/crc32_byte_engine_chk.sv
`timescale 1ns/1ps
module crc32_byte_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        seed_en,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_last,
  input logic        crc_valid,
  input logic [31:0] crc_out
);
  // R6
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    crc_valid |=> !crc_valid);
  // R6
  a_r6_ready_low: assert property (@(posedge clk) disable iff (rst)
    crc_valid |-> !in_ready);
  // R6
  a_r6_follows_last: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_last) |=> crc_valid);
  // R6
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    crc_valid |-> $past(in_ready && in_last));
  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !crc_valid |-> $stable(crc_out));
  // R4
  a_r4_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (start && !seed_en && in_last && !in_valid && in_ready) |=> (crc_out == 32'h0));
endmodule

bind crc32_byte_engine crc32_byte_engine_chk u_chk (.*);

// File: tb/crc32_byte_engine_bench.sv
`timescale 1ns/1ps
module crc32_byte_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        seed_en = 1'b0;
  logic [31:0] seed = '0;
  logic        poly_sel = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        crc_valid;
  logic [31:0] crc_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  crc32_byte_engine u_crc32_byte_engine (.*);

  // Bit-serial reference, one input bit per iteration.
  function automatic logic [31:0] ref_byte(input logic [31:0] s, input logic [7:0] b, input bit cast);
    logic [31:0] p = cast ? 32'h82F63B78 : 32'hEDB88320;
    for (int i = 0; i < 8; i++) begin
      logic fb = s[0] ^ b[i];
      s = s >> 1;
      if (fb) s = s ^ p;
    end
    return s;
  endfunction

  function automatic logic [31:0] ref_msg(input logic [7:0] q[$], input bit cast);
    logic [31:0] s = 32'hFFFFFFFF;
    foreach (q[i]) s = ref_byte(s, q[i], cast);
    return ~s;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Cycle-level shadow of the port behaviour.
  logic [31:0] m_state;
  logic        m_poly, m_ready, m_valid;
  logic [31:0] m_out;
  always @(posedge clk) begin
    if (rst) begin
      m_state <= 32'hFFFFFFFF; m_poly <= 1'b0; m_ready <= 1'b1; m_valid <= 1'b0; m_out <= '0;
    end else begin
      logic [31:0] b, ns;
      logic pe;
      b  = start ? ~(seed_en ? seed : 32'h0) : m_state;
      pe = start ? poly_sel : m_poly;
      if (start) m_poly <= poly_sel;
      ns = (in_valid && m_ready) ? ref_byte(b, in_data, pe) : b;
      m_state <= ns;
      m_valid <= 1'b0;
      m_ready <= 1'b1;
      if (in_last && m_ready) begin
        m_valid <= 1'b1; m_ready <= 1'b0; m_out <= ~ns;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(crc_valid === m_valid, "R6 model crc_valid", 32'(crc_valid), 32'(m_valid));
      chk(in_ready === m_ready, "R6 model in_ready", 32'(in_ready), 32'(m_ready));
      chk(crc_out === m_out, "R3 model crc_out", crc_out, m_out);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Sends one message; flips poly_sel during idle gaps when gap > 0.
  task automatic run_msg(input logic [7:0] q[$], input bit p, input bit sd, input logic [31:0] sv,
                         input int gap, output logic [31:0] res);
    start = 1'b1; poly_sel = p; seed_en = sd; seed = sv;
    if (q.size() == 0) begin
      in_valid = 1'b0; in_last = 1'b1;
      @(negedge clk);
      start = 1'b0; seed_en = 1'b0; in_last = 1'b0;
    end else begin
      for (int i = 0; i < q.size(); i++) begin
        in_valid = 1'b1; in_data = q[i]; in_last = (i == q.size() - 1);
        @(negedge clk);
        start = 1'b0; seed_en = 1'b0; poly_sel = p;
        if (i != q.size() - 1) begin
          for (int g = 0; g < gap; g++) begin
            in_valid = 1'b0; in_last = 1'b0; poly_sel = ~p; in_data = ~in_data;
            @(negedge clk);
          end
        end
      end
      in_valid = 1'b0; in_last = 1'b0;
    end
    chk(crc_valid === 1'b1, "R6 strobe after last", 32'(crc_valid), 32'd1);
    chk(in_ready === 1'b0, "R6 ready low at strobe", 32'(in_ready), 32'd0);
    res = crc_out;
    @(negedge clk);
    chk(crc_valid === 1'b0, "R6 strobe one cycle", 32'(crc_valid), 32'd0);
  endtask

  initial begin
    logic [7:0] hi[$], digits[$], head[$], tail[$], one[$], none[$], rq[$];
    logic [31:0] r, r2, held;
    hi = '{8'h48, 8'h69, 8'h0A};
    digits = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    head = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35};
    tail = '{8'h36, 8'h37, 8'h38, 8'h39};
    one = '{8'h00};
    none = {};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(in_ready === 1'b1, "R10 reset ready", 32'(in_ready), 32'd1);
    chk(crc_valid === 1'b0, "R10 reset valid", 32'(crc_valid), 32'd0);
    chk(crc_out === 32'h0, "R10 reset crc_out", crc_out, 32'h0);

    run_msg(hi, 1'b0, 1'b0, 32'h0, 0, r);
    chk(r === 32'hD5223C9A, "R1 three-byte vector", r, 32'hD5223C9A);
    run_msg(digits, 1'b0, 1'b0, 32'h0, 0, r);
    chk(r === 32'hCBF43926, "R1 digits vector", r, 32'hCBF43926);
    run_msg(digits, 1'b1, 1'b0, 32'h0, 0, r);
    chk(r === 32'hE3069283, "R2 Castagnoli digits", r, 32'hE3069283);

    // R7 and R8: idle gaps with poly_sel flipped and data wiggled
    run_msg(digits, 1'b0, 1'b0, 32'h0, 3, r);
    chk(r === 32'hCBF43926, "R7 gaps no effect", r, 32'hCBF43926);
    run_msg(digits, 1'b1, 1'b0, 32'h0, 2, r);
    chk(r === 32'hE3069283, "R8 poly change ignored", r, 32'hE3069283);

    run_msg(none, 1'b0, 1'b0, 32'h0, 0, r);
    chk(r === 32'h0, "R4 empty unseeded", r, 32'h0);
    run_msg(none, 1'b1, 1'b1, 32'h1234ABCD, 0, r);
    chk(r === 32'h1234ABCD, "R4 empty seeded returns seed", r, 32'h1234ABCD);

    run_msg(one, 1'b0, 1'b0, 32'h0, 0, r);
    chk(r === 32'hD202EF8D, "R9 one-byte start+last", r, 32'hD202EF8D);

    for (int p = 0; p < 2; p++) begin
      run_msg(head, p[0], 1'b0, 32'h0, 0, r);
      run_msg(tail, p[0], 1'b1, r, 1, r2);
      chk(r2 === ref_msg(digits, p[0]), "R5 resume from seed", r2, ref_msg(digits, p[0]));
    end

    held = crc_out;
    repeat (5) @(negedge clk);
    chk(crc_out === held, "R10 output held while idle", crc_out, held);

    for (int t = 0; t < 40; t++) begin
      int n;
      bit p;
      n = $urandom_range(0, 12);
      p = $urandom_range(0, 1);
      rq = {};
      for (int k = 0; k < n; k++) rq.push_back(8'($urandom_range(0, 255)));
      run_msg(rq, p, 1'b0, 32'h0, $urandom_range(0, 2), r);
      chk(r === ref_msg(rq, p), "R3 random message", r, ref_msg(rq, p));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule